// File: doc/BRIEF.md
# Raster Timing Generator with Separate Data-Valid Window

This block produces the per-clock strobes that frame a video raster: line sync, frame sync, display enable, an active-picture window and a data-valid window. It holds no pixels. It counts clocks across a frame and compares the count against window edges. Those edges are derived from porch, pulse and size values written through a simple register port.

The data-valid window is computed apart from the active window. It can therefore be narrower, which covers three cases: a link that carries two pixels per clock, a compressed stream whose payload per line is shorter than the raster, or both. The horizontal and vertical edges for a DisplayPort-style link follow their own rules, with the vertical window offset inside the line. In wide mode on such a link, the horizontal values are written already halved.

Register writes land in a staging copy. That copy becomes live only while the generator is stopped, or on the last clock of a frame, so a running frame is never torn. The register port and the strobes are plain pins with no handshake. A write completes in the cycle it is presented, and the strobes cannot be stalled.

Top module: `scanwin_top`

## Requirements
- R1: The line period is pulse + back porch + active width + front porch (horizontal values) in clocks. hsync is asserted for the first `pulse` clocks of every line.
- R2: The frame period is the vertical sum (pulse + back + active + front lines) times the line period, in clocks. vsync is asserted for the first vertical-pulse × line-period clocks of each frame.
- R3: For a non-DP link, display enable holds where the line position lies in [hpulse+hback, line period − hfront − 1] and the frame position lies in [(vpulse+vback) × line period, frame period − vfront × line period − 1]. disp_hctl carries the horizontal end in bits 31:16 and the start in bits 15:0.
- R4: For a non-DP link, the horizontal active window is on only when the active width differs from the visible width. It then spans [hstart, hstart + visible − 1]. The vertical active window is on only when the active lines differ from the visible lines. It then spans from the vertical display start for visible lines × line period clocks. An axis that is off follows display enable. active_hctl is {end, start} when the horizontal window is on, and 0 otherwise.
- R5: The data window starts at hstart and is `width` clocks long. With compression, width is ceil(line bytes / 3), halved (rounding down) in wide mode. With wide mode on a non-DP link and no compression, it is the active width halved. In all other cases it is the active width. data_valid also requires the vertical display window. data_hctl is {end, start}.
- R6: data_win_on is low only when compression is on and wide mode is off. In that case data_valid equals the unpolarized display enable. wide_on mirrors the wide-mode bit.
- R7: For a DP link, the vertical display start gains hpulse+hback and the vertical display end loses hfront. Display and active horizontal windows are both [hstart, hstart + visible − 1]. Both active windows are on, and the vertical active window spans visible lines × line period clocks from the display start.
- R8: For a DP link with compression, the data window is [hstart, hstart + extra cycles].
- R9: Register addresses are 0 hpulse, 1 hback, 2 hactive, 3 hfront, 4 hvisible, 5 vpulse, 6 vback, 7 vactive, 8 vfront, 9 vvisible, 10 mode, 11 line bytes, 12 extra cycles. Mode bits are 0 DP, 1 wide, 2 compress, 3 hsync invert, 4 vsync invert, 5 display-enable invert. Writes reach a staging copy, which goes live while run is low or on the last clock of a frame. A write during a frame leaves the rest of that frame unchanged.
- R10: A set invert bit makes the matching output (hsync, vsync or disp_en) active-low.
- R11: While run is low, the counters sit at zero and every strobe is at its inactive level. The first position is shown one clock after run rises. Reset values are horizontal 2, 3, 8, 2, 8 and vertical 1, 1, 4, 1, 4, with all mode bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write value |
| run | input | 1 | Generator enable |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| disp_en | output | 1 | Display enable |
| active_en | output | 1 | Active-picture window |
| data_valid | output | 1 | Data-valid window |
| disp_hctl | output | 32 | Display horizontal {end, start} |
| active_hctl | output | 32 | Active horizontal {end, start}, or 0 |
| data_hctl | output | 32 | Data horizontal {end, start} |
| act_h_on | output | 1 | Horizontal active window enabled |
| act_v_on | output | 1 | Vertical active window enabled |
| data_win_on | output | 1 | Data window control enabled |
| wide_on | output | 1 | Wide-mode flag |

## Verification
The hardest case to reach is a configuration change landing exactly on the frame boundary. The stimulus writes a new sync width a few clocks into a running frame. The model keeps the old values until the frame position wraps and then applies the new ones, so both the boundary clock and the next frame's first clock are compared. Stopping and restarting mid-frame shows that the strobes fall idle at once and restart from position zero. All eight combinations of link type, wide mode and compression run with a border-filled raster, and random rasters with random polarities run over the same mode space.

// File: rtl/scanwin_pkg.sv
package scanwin_pkg;
  localparam int FIELD_W = 16;
  localparam int POS_W   = 2 * FIELD_W;

  localparam int RA_HPULSE = 0;
  localparam int RA_HBACK  = 1;
  localparam int RA_HACT   = 2;
  localparam int RA_HFRONT = 3;
  localparam int RA_HVIS   = 4;
  localparam int RA_VPULSE = 5;
  localparam int RA_VBACK  = 6;
  localparam int RA_VACT   = 7;
  localparam int RA_VFRONT = 8;
  localparam int RA_VVIS   = 9;
  localparam int RA_MODE   = 10;
  localparam int RA_LBYTES = 11;
  localparam int RA_XTRA   = 12;

  localparam int STB_HS  = 0;
  localparam int STB_VS  = 1;
  localparam int STB_DE  = 2;
  localparam int STB_AC  = 3;
  localparam int STB_DV  = 4;
  localparam int NUM_STB = 5;

  typedef struct packed {
    logic [FIELD_W-1:0] h_pulse, h_back, h_act, h_front, h_vis;
    logic [FIELD_W-1:0] v_pulse, v_back, v_act, v_front, v_vis;
    logic [FIELD_W-1:0] line_bytes, xtra;
    logic is_dp, wide, comp, inv_h, inv_v, inv_de;
  } tcfg_t;

  typedef struct packed {
    logic [POS_W-1:0] h_period, f_total, vs_len;
    logic [POS_W-1:0] dh_s, dh_e, ah_s, ah_e, da_s, da_e;
    logic [POS_W-1:0] dv_s, dv_e, av_s, av_e;
    logic act_h_on, act_v_on, data_on;
  } win_t;

  function automatic logic [POS_W-1:0] zx(input logic [FIELD_W-1:0] v);
    return {{(POS_W-FIELD_W){1'b0}}, v};
  endfunction

  function automatic tcfg_t cfg_default();
    tcfg_t c;
    c = '0;
    c.h_pulse = FIELD_W'(2);
    c.h_back  = FIELD_W'(3);
    c.h_act   = FIELD_W'(8);
    c.h_front = FIELD_W'(2);
    c.h_vis   = FIELD_W'(8);
    c.v_pulse = FIELD_W'(1);
    c.v_back  = FIELD_W'(1);
    c.v_act   = FIELD_W'(4);
    c.v_front = FIELD_W'(1);
    c.v_vis   = FIELD_W'(4);
    return c;
  endfunction
endpackage

// File: rtl/scanwin_cfg_regs.sv
module scanwin_cfg_regs
  import scanwin_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               run,
  input  logic               frame_last,
  output tcfg_t              cfg_o
);
  tcfg_t stage_q, live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= cfg_default();
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(RA_HPULSE): stage_q.h_pulse    <= wr_data;
        ADDR_W'(RA_HBACK):  stage_q.h_back     <= wr_data;
        ADDR_W'(RA_HACT):   stage_q.h_act      <= wr_data;
        ADDR_W'(RA_HFRONT): stage_q.h_front    <= wr_data;
        ADDR_W'(RA_HVIS):   stage_q.h_vis      <= wr_data;
        ADDR_W'(RA_VPULSE): stage_q.v_pulse    <= wr_data;
        ADDR_W'(RA_VBACK):  stage_q.v_back     <= wr_data;
        ADDR_W'(RA_VACT):   stage_q.v_act      <= wr_data;
        ADDR_W'(RA_VFRONT): stage_q.v_front    <= wr_data;
        ADDR_W'(RA_VVIS):   stage_q.v_vis      <= wr_data;
        ADDR_W'(RA_LBYTES): stage_q.line_bytes <= wr_data;
        ADDR_W'(RA_XTRA):   stage_q.xtra       <= wr_data;
        ADDR_W'(RA_MODE): begin
          stage_q.is_dp  <= wr_data[0];
          stage_q.wide   <= wr_data[1];
          stage_q.comp   <= wr_data[2];
          stage_q.inv_h  <= wr_data[3];
          stage_q.inv_v  <= wr_data[4];
          stage_q.inv_de <= wr_data[5];
        end
        default: ;
      endcase
    end
  end

  // Live copy only moves when stopped or on the final clock of a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 live_q <= cfg_default();
    else if (!run || frame_last) live_q <= stage_q;
  end

  assign cfg_o = live_q;

  a_r9_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_last) |=> $stable(live_q));
endmodule

// File: rtl/scanwin_win_calc.sv
module scanwin_win_calc
  import scanwin_pkg::*;
(
  input  tcfg_t            cfg_i,
  output win_t             win_o,
  output logic [POS_W-1:0] disp_word_o,
  output logic [POS_W-1:0] active_word_o,
  output logic [POS_W-1:0] data_word_o
);
  logic [POS_W-1:0] hp, hb, ha, hf, hv, vp, vb, va, vf, vv, lb, xc;
  logic [POS_W-1:0] hper, vper, hstart, vis_end, dwid, dvs_base;
  win_t w;

  always_comb begin
    hp = zx(cfg_i.h_pulse);  hb = zx(cfg_i.h_back);  ha = zx(cfg_i.h_act);
    hf = zx(cfg_i.h_front);  hv = zx(cfg_i.h_vis);
    vp = zx(cfg_i.v_pulse);  vb = zx(cfg_i.v_back);  va = zx(cfg_i.v_act);
    vf = zx(cfg_i.v_front);  vv = zx(cfg_i.v_vis);
    lb = zx(cfg_i.line_bytes); xc = zx(cfg_i.xtra);

    hper    = hp + hb + ha + hf;
    vper    = vp + vb + va + vf;
    hstart  = hp + hb;
    vis_end = hstart + hv - POS_W'(1);

    w.h_period = hper;
    w.f_total  = vper * hper;
    w.vs_len   = vp * hper;

    w.act_h_on = cfg_i.is_dp | (cfg_i.h_act != cfg_i.h_vis);
    w.act_v_on = cfg_i.is_dp | (cfg_i.v_act != cfg_i.v_vis);
    w.data_on  = !cfg_i.comp || cfg_i.wide;

    w.dh_s = hstart;
    w.dh_e = cfg_i.is_dp ? vis_end : (hper - hf - POS_W'(1));
    w.ah_s = hstart;
    w.ah_e = vis_end;

    if (cfg_i.comp)
      dwid = ((lb + POS_W'(2)) / POS_W'(3)) >> (cfg_i.wide ? 1 : 0);
    else if (cfg_i.wide && !cfg_i.is_dp)
      dwid = ha >> 1;
    else
      dwid = ha;

    w.da_s = hstart;
    w.da_e = (cfg_i.is_dp && cfg_i.comp) ? (hstart + xc) : (hstart + dwid - POS_W'(1));

    dvs_base = (vp + vb) * hper;
    w.dv_s = cfg_i.is_dp ? (dvs_base + hstart) : dvs_base;
    w.dv_e = w.f_total - vf * hper - POS_W'(1) - (cfg_i.is_dp ? hf : '0);
    w.av_s = w.dv_s;
    w.av_e = w.dv_s + vv * hper - POS_W'(1);
  end

  assign win_o         = w;
  assign disp_word_o   = {w.dh_e[FIELD_W-1:0], w.dh_s[FIELD_W-1:0]};
  assign active_word_o = w.act_h_on ? {w.ah_e[FIELD_W-1:0], w.ah_s[FIELD_W-1:0]} : '0;
  assign data_word_o   = {w.da_e[FIELD_W-1:0], w.da_s[FIELD_W-1:0]};
endmodule

// File: rtl/scanwin_counter.sv
module scanwin_counter
  import scanwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [POS_W-1:0] h_period,
  input  logic [POS_W-1:0] f_total,
  output logic [POS_W-1:0] hcnt_o,
  output logic [POS_W-1:0] fcnt_o,
  output logic             frame_last_o
);
  logic [POS_W-1:0] hcnt_q, fcnt_q;
  logic             line_last;

  assign line_last    = (hcnt_q + POS_W'(1)) >= h_period;
  assign frame_last_o = run && ((fcnt_q + POS_W'(1)) >= f_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      fcnt_q <= '0;
    end else if (!run || frame_last_o) begin
      hcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      hcnt_q <= line_last ? '0 : hcnt_q + POS_W'(1);
      fcnt_q <= fcnt_q + POS_W'(1);
    end
  end

  assign hcnt_o = hcnt_q;
  assign fcnt_o = fcnt_q;

  a_r1_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_period != '0) |-> (hcnt_q < h_period));

  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last_o |=> (fcnt_q == '0 && hcnt_q == '0));
endmodule

// File: rtl/scanwin_strobe_gen.sv
module scanwin_strobe_gen
  import scanwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [POS_W-1:0]   hcnt,
  input  logic [POS_W-1:0]   fcnt,
  input  logic [POS_W-1:0]   h_pulse,
  input  logic [POS_W-1:0]   vs_len,
  input  logic [POS_W-1:0]   dh_s, dh_e, ah_s, ah_e, da_s, da_e,
  input  logic [POS_W-1:0]   dv_s, dv_e, av_s, av_e,
  input  logic               act_h_on,
  input  logic               act_v_on,
  input  logic               data_on,
  input  logic               inv_h,
  input  logic               inv_v,
  input  logic               inv_de,
  output logic [NUM_STB-1:0] strb_o
);
  logic [NUM_STB-1:0] lvl, pol, nxt, strb_q;
  logic in_dh, in_dv, in_ah, in_av, in_da;

  always_comb begin
    in_dh = (hcnt >= dh_s) && (hcnt <= dh_e);
    in_dv = (fcnt >= dv_s) && (fcnt <= dv_e);
    in_ah = act_h_on ? ((hcnt >= ah_s) && (hcnt <= ah_e)) : in_dh;
    in_av = act_v_on ? ((fcnt >= av_s) && (fcnt <= av_e)) : in_dv;
    in_da = (hcnt >= da_s) && (hcnt <= da_e);
    lvl[STB_HS] = hcnt < h_pulse;
    lvl[STB_VS] = fcnt < vs_len;
    lvl[STB_DE] = in_dh && in_dv;
    lvl[STB_AC] = in_ah && in_av;
    lvl[STB_DV] = data_on ? (in_da && in_dv) : (in_dh && in_dv);
  end

  assign pol = {2'b00, inv_de, inv_v, inv_h};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STB; gi++) begin : g_pol
      assign nxt[gi] = (run & lvl[gi]) ^ pol[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= '0;
    else        strb_q <= nxt;
  end

  assign strb_o = strb_q;

  a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (strb_q == $past(pol)));

  a_r6_dv_follows_de: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(data_on)) |->
      (strb_q[STB_DV] == (strb_q[STB_DE] ^ $past(inv_de))));
endmodule

// File: rtl/scanwin_top.sv
module scanwin_top
  import scanwin_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               run,
  output logic               hsync,
  output logic               vsync,
  output logic               disp_en,
  output logic               active_en,
  output logic               data_valid,
  output logic [POS_W-1:0]   disp_hctl,
  output logic [POS_W-1:0]   active_hctl,
  output logic [POS_W-1:0]   data_hctl,
  output logic               act_h_on,
  output logic               act_v_on,
  output logic               data_win_on,
  output logic               wide_on
);
  tcfg_t              cfg;
  win_t               win;
  logic [POS_W-1:0]   hcnt, fcnt;
  logic               frame_last;
  logic [NUM_STB-1:0] strb;

  scanwin_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .frame_last(frame_last), .cfg_o(cfg)
  );

  scanwin_win_calc u_win (
    .cfg_i(cfg), .win_o(win), .disp_word_o(disp_hctl),
    .active_word_o(active_hctl), .data_word_o(data_hctl)
  );

  scanwin_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .h_period(win.h_period),
    .f_total(win.f_total), .hcnt_o(hcnt), .fcnt_o(fcnt),
    .frame_last_o(frame_last)
  );

  scanwin_strobe_gen u_stb (
    .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .h_pulse(zx(cfg.h_pulse)), .vs_len(win.vs_len),
    .dh_s(win.dh_s), .dh_e(win.dh_e), .ah_s(win.ah_s), .ah_e(win.ah_e),
    .da_s(win.da_s), .da_e(win.da_e), .dv_s(win.dv_s), .dv_e(win.dv_e),
    .av_s(win.av_s), .av_e(win.av_e), .act_h_on(win.act_h_on),
    .act_v_on(win.act_v_on), .data_on(win.data_on), .inv_h(cfg.inv_h),
    .inv_v(cfg.inv_v), .inv_de(cfg.inv_de), .strb_o(strb)
  );

  assign hsync       = strb[STB_HS];
  assign vsync       = strb[STB_VS];
  assign disp_en     = strb[STB_DE];
  assign active_en   = strb[STB_AC];
  assign data_valid  = strb[STB_DV];
  assign act_h_on    = win.act_h_on;
  assign act_v_on    = win.act_v_on;
  assign data_win_on = win.data_on;
  assign wide_on     = cfg.wide;
endmodule

// File: tb/scanwin_top_tb_top.sv
`timescale 1ns/1ps
module scanwin_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic run = 1'b0;
  logic hsync, vsync, disp_en, active_en, data_valid;
  logic [31:0] disp_hctl, active_hctl, data_hctl;
  logic act_h_on, act_v_on, data_win_on, wide_on;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  scanwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .active_en(active_en), .data_valid(data_valid), .disp_hctl(disp_hctl),
    .active_hctl(active_hctl), .data_hctl(data_hctl), .act_h_on(act_h_on),
    .act_v_on(act_v_on), .data_win_on(data_win_on), .wide_on(wide_on)
  );

  typedef struct {
    int hp, hb, hw, hf, hr, vp, vb, vh, vf, vr, lb, xc;
    bit dp, wide, comp, ph, pv, pd;
  } tcfg_t;

  function automatic int hper(tcfg_t c); return c.hp + c.hb + c.hw + c.hf; endfunction
  function automatic int ftot(tcfg_t c); return (c.vp + c.vb + c.vh + c.vf) * hper(c); endfunction
  function automatic int hst(tcfg_t c); return c.hp + c.hb; endfunction
  function automatic int dh_end(tcfg_t c);
    return c.dp ? hst(c) + c.hr - 1 : hper(c) - c.hf - 1;
  endfunction
  function automatic int dwidth(tcfg_t c);
    if (c.comp) return c.wide ? ((c.lb + 2) / 3) / 2 : (c.lb + 2) / 3;
    if (c.wide && !c.dp) return c.hw / 2;
    return c.hw;
  endfunction
  function automatic int da_end(tcfg_t c);
    return (c.dp && c.comp) ? hst(c) + c.xc : hst(c) + dwidth(c) - 1;
  endfunction
  function automatic int dv_start(tcfg_t c);
    return (c.vp + c.vb) * hper(c) + (c.dp ? hst(c) : 0);
  endfunction
  function automatic int dv_end(tcfg_t c);
    return ftot(c) - c.vf * hper(c) - 1 - (c.dp ? c.hf : 0);
  endfunction
  function automatic bit ah_en(tcfg_t c); return c.dp || (c.hw != c.hr); endfunction
  function automatic bit av_en(tcfg_t c); return c.dp || (c.vh != c.vr); endfunction
  function automatic logic [31:0] pack(int e, int s); return {e[15:0], s[15:0]}; endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string pick(string ov, string dflt);
    return (ov != "") ? ov : dflt;
  endfunction

  task automatic chk_words(input tcfg_t c, input string ov);
    chk(pick(ov, c.dp ? "R7" : "R3"), "disp_hctl", disp_hctl, pack(dh_end(c), hst(c)));
    chk(pick(ov, c.dp ? "R7" : "R4"), "active_hctl", active_hctl,
        ah_en(c) ? pack(hst(c) + c.hr - 1, hst(c)) : 32'h0);
    chk(pick(ov, (c.dp && c.comp) ? "R8" : "R5"), "data_hctl", data_hctl, pack(da_end(c), hst(c)));
    chk(pick(ov, "R6"), "data_win_on", {31'b0, data_win_on}, {31'b0, !c.comp || c.wide});
    chk(pick(ov, "R6"), "wide_on", {31'b0, wide_on}, {31'b0, c.wide});
    chk(pick(ov, c.dp ? "R7" : "R4"), "act_h_on", {31'b0, act_h_on}, {31'b0, ah_en(c)});
    chk(pick(ov, c.dp ? "R7" : "R4"), "act_v_on", {31'b0, act_v_on}, {31'b0, av_en(c)});
  endtask

  task automatic chk_idle(input tcfg_t c);
    chk("R11", "idle hsync", {31'b0, hsync}, {31'b0, c.ph});
    chk("R11", "idle vsync", {31'b0, vsync}, {31'b0, c.pv});
    chk("R11", "idle disp_en", {31'b0, disp_en}, {31'b0, c.pd});
    chk("R11", "idle active_en", {31'b0, active_en}, 32'h0);
    chk("R11", "idle data_valid", {31'b0, data_valid}, 32'h0);
  endtask

  task automatic sample(input tcfg_t c, input int pos, input string ov);
    int hp1 = hper(c);
    int h = pos % hp1;
    bit inh = (h >= hst(c)) && (h <= dh_end(c));
    bit inv = (pos >= dv_start(c)) && (pos <= dv_end(c));
    bit de = inh && inv;
    bit ah = ah_en(c) ? ((h >= hst(c)) && (h <= hst(c) + c.hr - 1)) : inh;
    bit av = av_en(c) ? ((pos >= dv_start(c)) && (pos <= dv_start(c) + c.vr * hp1 - 1)) : inv;
    bit dv = (!c.comp || c.wide) ? ((h >= hst(c)) && (h <= da_end(c)) && inv) : de;
    chk(pick(ov, c.ph ? "R10" : "R1"), "hsync", {31'b0, hsync}, {31'b0, (h < c.hp) ^ c.ph});
    chk(pick(ov, c.pv ? "R10" : "R2"), "vsync", {31'b0, vsync}, {31'b0, (pos < c.vp * hp1) ^ c.pv});
    chk(pick(ov, c.pd ? "R10" : (c.dp ? "R7" : "R3")), "disp_en", {31'b0, disp_en}, {31'b0, de ^ c.pd});
    chk(pick(ov, c.dp ? "R7" : "R4"), "active_en", {31'b0, active_en}, {31'b0, ah && av});
    chk(pick(ov, (c.dp && c.comp) ? "R8" : ((!c.comp || c.wide) ? "R5" : "R6")), "data_valid",
        {31'b0, data_valid}, {31'b0, dv});
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_cfg(input tcfg_t c);
    run = 1'b0;
    @(negedge clk);
    wr(0, c.hp); wr(1, c.hb); wr(2, c.hw); wr(3, c.hf); wr(4, c.hr);
    wr(5, c.vp); wr(6, c.vb); wr(7, c.vh); wr(8, c.vf); wr(9, c.vr);
    wr(10, {26'b0, c.pd, c.pv, c.ph, c.comp, c.wide, c.dp});
    wr(11, c.lb); wr(12, c.xc);
    repeat (3) @(negedge clk);
    chk_idle(c);
    chk_words(c, "");
  endtask

  task automatic run_frames(input tcfg_t c, input int ncyc);
    int pos = 0;
    run = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      sample(c, pos, "");
      if (pos == 0) chk_words(c, "");
      pos = (pos + 1) % ftot(c);
    end
    run = 1'b0;
  endtask

  function automatic tcfg_t base_cfg();
    tcfg_t c;
    c.hp = 2; c.hb = 2; c.hw = 10; c.hf = 3; c.hr = 8;
    c.vp = 1; c.vb = 1; c.vh = 4; c.vf = 1; c.vr = 3;
    c.lb = 20; c.xc = 3;
    c.dp = 0; c.wide = 0; c.comp = 0; c.ph = 0; c.pv = 0; c.pd = 0;
    return c;
  endfunction

  function automatic tcfg_t rand_cfg();
    tcfg_t c;
    c.hp = $urandom_range(4, 1); c.hb = $urandom_range(3, 0);
    c.hw = $urandom_range(12, 2); c.hf = $urandom_range(4, 0);
    c.hr = ($urandom_range(1, 0) == 1) ? c.hw : $urandom_range(c.hw, 1);
    c.vp = $urandom_range(2, 1); c.vb = $urandom_range(2, 0);
    c.vh = $urandom_range(5, 2); c.vf = $urandom_range(2, 0);
    c.vr = ($urandom_range(1, 0) == 1) ? c.vh : $urandom_range(c.vh, 1);
    c.lb = $urandom_range(48, 1); c.xc = $urandom_range(4, 0);
    c.dp = $urandom_range(1, 0) == 1; c.wide = $urandom_range(1, 0) == 1;
    c.comp = $urandom_range(1, 0) == 1; c.ph = $urandom_range(1, 0) == 1;
    c.pv = $urandom_range(1, 0) == 1; c.pd = $urandom_range(1, 0) == 1;
    return c;
  endfunction

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tcfg_t c, p, d;
    int pos;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state and reset register values
    d = base_cfg();
    d.hb = 3; d.hw = 8; d.hf = 2; d.hr = 8; d.vr = 4; d.lb = 0; d.xc = 0;
    chk_idle(d);
    chk_words(d, "R11");

    // Directed: every combination of link type, wide mode and compression
    for (int m = 0; m < 8; m++) begin
      c = base_cfg();
      c.dp = m[0]; c.wide = m[1]; c.comp = m[2];
      load_cfg(c);
      run_frames(c, ftot(c) + 12);
    end

    // Constrained random rasters, modes and polarities
    for (int i = 0; i < 24; i++) begin
      c = rand_cfg();
      load_cfg(c);
      run_frames(c, ftot(c) + 20);
    end

    // R9: write mid-frame, old values hold until the frame boundary
    c = base_cfg();
    load_cfg(c);
    p = c;
    pos = 0;
    run = 1'b1;
    for (int k = 0; k < 2 * ftot(c) + 40; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      sample(c, pos, "R9");
      if (pos == 0) chk_words(c, "R9");
      if (k == 3) begin
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 16'd4;
        p.hp = 4;
      end
      pos = pos + 1;
      if (pos == ftot(c)) begin
        pos = 0;
        c = p;
      end
    end

    // R11: stop mid-frame, strobes idle, restart from position zero
    @(negedge clk);
    sample(c, pos, "R9");
    run = 1'b0;
    @(negedge clk);
    chk_idle(c);
    run_frames(c, 30);
    @(negedge clk);
    chk_idle(c);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule